// File: doc/BRIEF.md
# Two-Phase Bus Protocol Monitor

This block sits beside a simple non-pipelined, single-slave bus and watches it without driving anything. On every rising clock edge it turns the select and enable lines into one of four conceptual bus states: idle, setup, transfer, or an illegal combination. It then checks that the sequence of states is legal. It also checks that the control, address and write data that were presented in the setup cycle are still presented, unchanged, in the transfer cycle that follows.

Each rule has its own sticky violation bit, so a test or a debug register can see which rule broke. A one-cycle error pulse flags every edge at which any rule failed, and the decoded state is available as a live output for tracing. All checks are built as plain synchronous logic, so the monitor can be kept in silicon as well as used in simulation.

Top module: `bpc_monitor`

## Requirements
- R1: While `rst_n` is low at a rising edge, all bits of `viol_o` and `err_o` are cleared at that edge, and `state_o` reads 2'b00 (idle) whatever select and enable do.
- R2: With `rst_n` high, `state_o` shows the live decode with bit 1 = `sel` and bit 0 = `en`: 2'b00 idle, 2'b10 setup, 2'b11 transfer, 2'b01 illegal.
- R3: An edge that samples enable high with select low sets `viol_o[0]` after that edge.
- R4: If the first edge sampled after reset is released does not see the idle state, `viol_o[1]` is set.
- R5: An idle state followed at the next edge by a transfer state sets `viol_o[2]`.
- R6: A setup state followed at the next edge by any state other than transfer sets `viol_o[3]`.
- R7: A transfer state followed at the next edge by another transfer state sets `viol_o[4]`.
- R8: After a setup state, if the next edge sees select low, or an address or write bit different from the setup cycle, `viol_o[5]` is set.
- R9: After a setup state with the write bit high, a different write data value at the next edge sets `viol_o[6]`; after a read setup the write data is ignored and `viol_o[6]` stays clear.
- R10: Every `viol_o` bit, once set, stays set until a reset edge.
- R11: `err_o` is high for exactly the cycle after each edge at which at least one rule failed, and low after any edge at which none failed.
- R12: Legal traffic (idle, setup then transfer with held values, back to idle or setup) leaves all `viol_o` bits and `err_o` clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| sel | input | 1 | Slave select seen on the bus |
| en | input | 1 | Transfer enable seen on the bus |
| wr | input | 1 | Direction bit, high for a write |
| addr | input | ADDR_W | Bus address |
| wdata | input | DATA_W | Write data |
| state_o | output | 2 | Live decoded bus state |
| viol_o | output | 7 | Sticky per-rule violation flags |
| err_o | output | 1 | One-cycle pulse after any failing edge |

## Verification
The properties assume the bus inputs are stable around the rising edge and that `rst_n` is applied for at least one edge before traffic starts; they do not assume the bus is legal, since catching illegal traffic is the point. The stimulus changes every input half a cycle away from the sampling edge and begins each sequence with a reset. It then deliberately walks through every three-state sequence of select and enable, legal and illegal alike, plus setup-to-transfer pairs that disturb one held field at a time.

// File: rtl/bpc_pkg.sv
package bpc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_BAD   = 2'b01,
    ST_SETUP = 2'b10,
    ST_XFER  = 2'b11
  } bus_state_e;

  localparam int NRULE     = 7;
  localparam int RB_BAD    = 0;
  localparam int RB_FIRST  = 1;
  localparam int RB_IDLE   = 2;
  localparam int RB_SETUP  = 3;
  localparam int RB_XFER   = 4;
  localparam int RB_HCTL   = 5;
  localparam int RB_HDATA  = 6;
  localparam int NSEQ      = 5;
endpackage

// File: rtl/bpc_decode.sv
module bpc_decode
  import bpc_pkg::*;
(
  input  logic       rst_n,
  input  logic       sel,
  input  logic       en,
  output bus_state_e st
);
  always_comb begin
    if (!rst_n) st = ST_IDLE;
    else        st = bus_state_e'({sel, en});
  end
endmodule

// File: rtl/bpc_seq_rules.sv
module bpc_seq_rules
  import bpc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  bus_state_e      st,
  output logic            prev_setup,
  output logic [NSEQ-1:0] fail
);
  bus_state_e prev_q;
  logic       first_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q  <= ST_IDLE;
      first_q <= 1'b1;
    end else begin
      prev_q  <= st;
      first_q <= 1'b0;
    end
  end

  assign prev_setup = (prev_q == ST_SETUP);

  always_comb begin
    fail           = '0;
    fail[RB_BAD]   = (st == ST_BAD);
    fail[RB_FIRST] = first_q && (st != ST_IDLE);
    fail[RB_IDLE]  = (prev_q == ST_IDLE) && (st == ST_XFER);
    fail[RB_SETUP] = (prev_q == ST_SETUP) && (st != ST_XFER);
    fail[RB_XFER]  = (prev_q == ST_XFER) && (st == ST_XFER);
  end
endmodule

// File: rtl/bpc_hold.sv
module bpc_hold
  import bpc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bus_state_e        st,
  input  logic              prev_setup,
  input  logic              sel,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              fail_ctl,
  output logic              fail_data
);
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              wr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      wr_q    <= 1'b0;
    end else if (st == ST_SETUP) begin
      addr_q  <= addr;
      wdata_q <= wdata;
      wr_q    <= wr;
    end
  end

  assign fail_ctl  = prev_setup && (!sel || (addr != addr_q) || (wr != wr_q));
  assign fail_data = prev_setup && wr_q && (wdata != wdata_q);
endmodule

// File: rtl/bpc_monitor.sv
module bpc_monitor
  import bpc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              en,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [1:0]        state_o,
  output logic [NRULE-1:0]  viol_o,
  output logic              err_o
);
  bus_state_e      st;
  logic            prev_setup;
  logic [NSEQ-1:0] seq_fail;
  logic            hold_ctl, hold_data;
  logic [NRULE-1:0] fail_now;
  logic [NRULE-1:0] viol_q;
  logic             err_q;

  bpc_decode u_dec (.rst_n(rst_n), .sel(sel), .en(en), .st(st));

  bpc_seq_rules u_seq (
    .clk(clk), .rst_n(rst_n), .st(st),
    .prev_setup(prev_setup), .fail(seq_fail)
  );

  bpc_hold #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .st(st), .prev_setup(prev_setup),
    .sel(sel), .wr(wr), .addr(addr), .wdata(wdata),
    .fail_ctl(hold_ctl), .fail_data(hold_data)
  );

  assign fail_now = {hold_data, hold_ctl, seq_fail};

  for (genvar g = 0; g < NRULE; g++) begin : g_sticky
    always_ff @(posedge clk) begin
      if (!rst_n)           viol_q[g] <= 1'b0;
      else if (fail_now[g]) viol_q[g] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= |fail_now;
  end

  assign state_o = st;
  assign viol_o  = viol_q;
  assign err_o   = err_q;
endmodule

// File: rtl/bpc_monitor_chk.sv
module bpc_monitor_chk
  import bpc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sel,
  input logic              en,
  input logic              wr,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic [1:0]        state_o,
  input logic [NRULE-1:0]  viol_o,
  input logic              err_o
);
  logic armed;
  always_ff @(posedge clk) begin
    if (!rst_n) armed <= 1'b1;
  end

  // R1
  always @(negedge clk) begin
    if (rst_n === 1'b0) begin
      idle_in_reset_chk: assert (state_o == 2'b00);
    end
  end

  // R3
  bad_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !sel) |=> viol_o[RB_BAD] && err_o);

  // R6
  setup_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !en) ##1 !(sel && en) |=> viol_o[RB_SETUP]);

  // R7
  xfer_twice_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && en) ##1 (sel && en) |=> viol_o[RB_XFER]);

  // R8
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !en) ##1 (addr != $past(addr)) |=> viol_o[RB_HCTL]);

  // R9
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !en && wr) ##1 (wdata != $past(wdata)) |=> viol_o[RB_HDATA]);

  // R10
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(rst_n)) |-> ((viol_o & $past(viol_o)) == $past(viol_o)));

  // R11
  pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (viol_o != '0));
endmodule

bind bpc_monitor bpc_monitor_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel(sel), .en(en), .wr(wr), .addr(addr),
  .wdata(wdata), .state_o(state_o), .viol_o(viol_o), .err_o(err_o)
);

// File: tb/test_bpc_monitor.sv
`timescale 1ns/1ps
module test_bpc_monitor;
  localparam int AW = 4;
  localparam int DW = 4;
  localparam int NR = 7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sel = 1'b0, en = 1'b0, wr = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [1:0]    state_o;
  logic [NR-1:0] viol_o;
  logic          err_o;

  int checks = 0;
  int failures = 0;

  // reference model state
  logic [1:0]    m_prev;
  logic          m_first;
  logic [AW-1:0] m_addr;
  logic [DW-1:0] m_wd;
  logic          m_wr;
  logic [NR-1:0] m_sticky;
  logic          m_err;

  always #10 clk = ~clk;

  bpc_monitor #(.ADDR_W(AW), .DATA_W(DW)) i_bpc_monitor (
    .clk(clk), .rst_n(rst_n), .sel(sel), .en(en), .wr(wr), .addr(addr),
    .wdata(wdata), .state_o(state_o), .viol_o(viol_o), .err_o(err_o)
  );

  function automatic string rule_tag(int b);
    case (b)
      0: return "R3";
      1: return "R4";
      2: return "R5";
      3: return "R6";
      4: return "R7";
      5: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_flags();
    for (int b = 0; b < NR; b++)
      check(viol_o[b] === m_sticky[b], {rule_tag(b), "/R10"}, viol_o[b], m_sticky[b]);
    check(err_o === m_err, "R11", err_o, m_err);
    if (m_sticky == '0)
      check(viol_o === '0, "R12", viol_o, 0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; sel = 1'b1; en = 1'b1;
    #1 check(state_o === 2'b00, "R1", state_o, 0);
    @(posedge clk); @(negedge clk);
    check(viol_o === '0 && err_o === 1'b0, "R1", {err_o, viol_o}, 0);
    m_prev = 2'b00; m_first = 1'b1; m_sticky = '0; m_err = 1'b0;
    m_addr = '0; m_wd = '0; m_wr = 1'b0;
    rst_n = 1'b1; sel = 1'b0; en = 1'b0;
  endtask

  task automatic step(logic s, logic e, logic w, logic [AW-1:0] a, logic [DW-1:0] d);
    logic [1:0]    cur;
    logic [NR-1:0] f;
    sel = s; en = e; wr = w; addr = a; wdata = d;
    cur = {s, e};
    #1 check(state_o === cur, "R2", state_o, cur);
    f = '0;
    f[0] = (cur == 2'b01);
    f[1] = m_first && (cur != 2'b00);
    f[2] = (m_prev == 2'b00) && (cur == 2'b11);
    f[3] = (m_prev == 2'b10) && (cur != 2'b11);
    f[4] = (m_prev == 2'b11) && (cur == 2'b11);
    f[5] = (m_prev == 2'b10) && (!s || a != m_addr || w != m_wr);
    f[6] = (m_prev == 2'b10) && m_wr && (d != m_wd);
    m_sticky = m_sticky | f;
    m_err = |f;
    if (cur == 2'b10) begin m_addr = a; m_wd = d; m_wr = w; end
    m_prev = cur; m_first = 1'b0;
    @(posedge clk); @(negedge clk);
    check_flags();
  endtask

  initial begin
    @(negedge clk);
    // exhaustive three-state sequences of {sel,en}
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        for (int c = 0; c < 4; c++) begin
          do_reset();
          step(a[1], a[0], 1'b1, 4'h5, 4'hA);
          step(b[1], b[0], 1'b1, 4'h5, 4'hA);
          step(c[1], c[0], 1'b1, 4'h5, 4'hA);
        end
    // held-field disturbance, write and read setups (R8, R9)
    for (int w = 0; w < 2; w++)
      for (int k = 0; k < 5; k++) begin
        do_reset();
        step(1'b0, 1'b0, 1'b0, 4'h0, 4'h0);
        step(1'b1, 1'b0, w[0], 4'h3, 4'hC);
        case (k)
          0: step(1'b1, 1'b1, w[0], 4'h3, 4'hC);
          1: step(1'b1, 1'b1, w[0], 4'h7, 4'hC);
          2: step(1'b1, 1'b1, ~w[0], 4'h3, 4'hC);
          3: step(1'b1, 1'b1, w[0], 4'h3, 4'h1);
          default: step(1'b0, 1'b0, w[0], 4'h3, 4'hC);
        endcase
        // legal traffic afterwards: flags must persist (R10) or stay clear (R12)
        step(1'b1, 1'b0, 1'b0, 4'h9, 4'h2);
        step(1'b1, 1'b1, 1'b0, 4'h9, 4'hF);
        step(1'b0, 1'b0, 1'b0, 4'h9, 4'hF);
      end
    // reset after violations clears everything (R1)
    step(1'b0, 1'b1, 1'b0, 4'h0, 4'h0);
    do_reset();
    step(1'b0, 1'b0, 1'b0, 4'h0, 4'h0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule